// File: doc/BRIEF.md
# Hall-Sensor Commutation Controller for a Three-Phase Bridge

This block turns the three digital levels of a brushless motor's Hall sensors into enables for the six switches of a three-phase half-bridge. Each phase has one high-side switch and one low-side switch. It decodes the six valid rotor positions into one sourcing phase and one sinking phase. Reverse rotation is produced by complementing the Hall code before the decode.

The remaining inputs are direction, an active-low short-brake request, a stop request and a chopping gate. An external PWM source drives the chopping gate high whenever the low side may conduct. Chopping acts only on the low-side switch of the active step; the high-side switch stays on for the whole step.

Every input passes through a two-flop synchronizer, and all outputs are registered. Whenever the synchronized direction or brake level changes, the bridge is blanked for a parameterized dead time. A composite Hall pulse (the parity of the three Hall bits) is provided for rotation sensing.

Top module: `bldc_commutator`

## Requirements
- R1: Phases are mapped as bit 0 = phase A, bit 1 = B, bit 2 = C. The Hall code is {hall_i[2], hall_i[1], hall_i[0]}. In forward direction (dir_rev_i = 0), the codes map to a source (high-side) and a sink (low-side) phase as follows: 101 → source B, sink A; 100 → source C, sink A; 110 → source C, sink B; 010 → source A, sink B; 011 → source A, sink C; 001 → source B, sink C.
- R2: With dir_rev_i = 1, the source and sink are chosen as in R1 for the bitwise complement of the Hall code.
- R3: Hall codes 000 and 111 drive all six enables to 0.
- R4: While the synchronized brake_n_i is 0 (and no stop or dead time applies), hi_en_o = 111 and lo_en_o = 000, whatever the Hall code.
- R5: While the synchronized stop_i is 1, all six enables are 0. This takes priority over brake and decode.
- R6: A 0 on the synchronized pwm_gate_i clears the active low-side enable only; the high-side enable of the step is unaffected.
- R7: A change of the synchronized direction or brake level forces all enables to 0 for DEAD_CYCLES+1 consecutive output cycles, starting with the cycle that sees the change. A further change during this window restarts it.
- R8: hall_comp_o is the XOR of the three Hall bits, independent of stop, brake and dead time.
- R9: Inputs pass through two synchronizer flops and one output register. An input applied before clock edge k is reflected in the outputs after edge k+2.
- R10: While rst_n is 0, all outputs are 0. The synchronizers reset to forward, no brake, stopped, gate low and Hall 000.
- R11: hi_en_o and lo_en_o are never 1 on the same phase in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall levels {C, B, A} |
| dir_rev_i | input | 1 | 1 selects reverse rotation |
| brake_n_i | input | 1 | 0 requests short brake |
| stop_i | input | 1 | 1 stops the drive, 0 allows it |
| pwm_gate_i | input | 1 | 1 lets the active low side conduct |
| hi_en_o | output | 3 | High-side switch enables, per phase |
| lo_en_o | output | 3 | Low-side switch enables, per phase |
| hall_comp_o | output | 1 | Parity of the Hall levels |

## Verification
The assertions are written on the synchronized copies of the inputs, so they take no view of metastability. They assume only that each input settles before the next clock edge. The bench meets this by changing every input on the falling edge.

The bench also covers direction and brake flips that arrive inside an open dead-time window, so that the restart rule is exercised. It includes long random stretches in which direction, brake and stop change rarely, while Hall and gate change often.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    typedef struct packed {
        logic [2:0] hall;
        logic       dir_rev;
        logic       brake_n;
        logic       stop;
        logic       pwm;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // reset image of the synchronized controls: forward, no brake, stopped
    localparam ctrl_t CTRL_RST = '{hall: 3'b000, dir_rev: 1'b0, brake_n: 1'b1,
                                   stop: 1'b1, pwm: 1'b0};

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
        logic       comp;
    } drive_t;

endpackage

// File: rtl/bldc_sync.sv
module bldc_sync #(
    parameter int                WIDTH   = 7,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bldc_decode.sv
module bldc_decode (
    input  logic [2:0] hall_i,
    input  logic       rev_i,
    output logic [2:0] src_o,
    output logic [2:0] snk_o,
    output logic       valid_o
);

    logic [2:0] code;

    always_comb begin
        code    = rev_i ? ~hall_i : hall_i;
        src_o   = 3'b000;
        snk_o   = 3'b000;
        valid_o = 1'b1;
        unique case (code)
            3'b101: begin src_o = 3'b010; snk_o = 3'b001; end
            3'b100: begin src_o = 3'b100; snk_o = 3'b001; end
            3'b110: begin src_o = 3'b100; snk_o = 3'b010; end
            3'b010: begin src_o = 3'b001; snk_o = 3'b010; end
            3'b011: begin src_o = 3'b001; snk_o = 3'b100; end
            3'b001: begin src_o = 3'b010; snk_o = 3'b100; end
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bldc_deadtime.sv
module bldc_deadtime #(
    parameter int DEAD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_i,
    input  logic brake_n_i,
    output logic blank_o
);

    localparam int CW = $clog2(DEAD_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dir;
        logic          brake_n;
    } dt_state_t;

    dt_state_t st_d, st_q;
    logic      change;

    always_comb begin
        st_d         = st_q;
        change       = (dir_i != st_q.dir) || (brake_n_i != st_q.brake_n);
        st_d.dir     = dir_i;
        st_d.brake_n = brake_n_i;
        if (change) begin
            st_d.cnt = CW'(DEAD_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        blank_o = change || (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: 1'b0, brake_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
    parameter int DEAD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_i,
    input  logic       dir_rev_i,
    input  logic       brake_n_i,
    input  logic       stop_i,
    input  logic       pwm_gate_i,
    output logic [2:0] hi_en_o,
    output logic [2:0] lo_en_o,
    output logic       hall_comp_o
);

    import bldc_pkg::*;

    ctrl_t      raw, syn;
    logic [2:0] src, snk;
    logic       valid, blank;
    drive_t     drv_d, drv_q;

    assign raw = '{hall: hall_i, dir_rev: dir_rev_i, brake_n: brake_n_i,
                   stop: stop_i, pwm: pwm_gate_i};

    bldc_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTRL_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (syn)
    );

    bldc_decode u_dec (
        .hall_i (syn.hall),
        .rev_i  (syn.dir_rev),
        .src_o  (src),
        .snk_o  (snk),
        .valid_o(valid)
    );

    bldc_deadtime #(
        .DEAD_CYCLES(DEAD_CYCLES)
    ) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_i    (syn.dir_rev),
        .brake_n_i(syn.brake_n),
        .blank_o  (blank)
    );

    always_comb begin
        drv_d      = '0;
        drv_d.comp = ^syn.hall;
        if (!syn.stop && !blank) begin
            if (!syn.brake_n) begin
                drv_d.hi = 3'b111;
            end else if (valid) begin
                drv_d.hi = src;
                drv_d.lo = syn.pwm ? snk : 3'b000;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign hi_en_o     = drv_q.hi;
    assign lo_en_o     = drv_q.lo;
    assign hall_comp_o = drv_q.comp;

endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_s,
    input logic       brake_n_s,
    input logic       pwm_s,
    input logic       blank,
    input logic [2:0] hi_en_o,
    input logic [2:0] lo_en_o
);

    // R11
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_o & lo_en_o) == 3'b000);

    // R5
    stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> (hi_en_o == 3'b000 && lo_en_o == 3'b000));

    // R4
    brake_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_n_s |=> lo_en_o == 3'b000);

    // R6
    gate_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_s |=> lo_en_o == 3'b000);

    // R7
    dead_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (hi_en_o == 3'b000 && lo_en_o == 3'b000));

    // R1
    single_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lo_en_o));

    // R1
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brake_n_s |=> $onehot0(hi_en_o));

endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_s   (syn.stop),
    .brake_n_s(syn.brake_n),
    .pwm_s    (syn.pwm),
    .blank    (blank),
    .hi_en_o  (hi_en_o),
    .lo_en_o  (lo_en_o)
);

// File: tb/tb_bldc_commutator.sv
`timescale 1ns/1ps
module tb_bldc_commutator;

    localparam int DEAD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b101;
    logic       dir_rev = 1'b0;
    logic       brake_n = 1'b1;
    logic       stop = 1'b0;
    logic       pwm = 1'b1;
    logic [2:0] hi_en, lo_en;
    logic       comp;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bldc_commutator #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_rev_i(dir_rev),
        .brake_n_i(brake_n), .stop_i(stop), .pwm_gate_i(pwm),
        .hi_en_o(hi_en), .lo_en_o(lo_en), .hall_comp_o(comp)
    );

    // inputs packed as {hall[2:0], dir, brake_n, stop, pwm}
    logic [6:0] hist [$];
    int         prev_dir, prev_brk, dead_left;
    logic [2:0] exp_hi, exp_lo;
    logic       exp_comp;
    string      exp_tag;

    function automatic void table_lookup(input logic [2:0] c, output logic [2:0] s,
                                         output logic [2:0] k, output bit ok);
        ok = 1'b1;
        case (c)
            3'b101: begin s = 3'b010; k = 3'b001; end
            3'b100: begin s = 3'b100; k = 3'b001; end
            3'b110: begin s = 3'b100; k = 3'b010; end
            3'b010: begin s = 3'b001; k = 3'b010; end
            3'b011: begin s = 3'b001; k = 3'b100; end
            3'b001: begin s = 3'b010; k = 3'b100; end
            default: begin s = 3'b000; k = 3'b000; ok = 1'b0; end
        endcase
    endfunction

    // R9: reference model with a two-sample input delay plus output register
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            prev_dir = 0; prev_brk = 1; dead_left = 0;
            exp_hi = 3'b000; exp_lo = 3'b000; exp_comp = 1'b0; exp_tag = "R10";
        end else begin
            logic [6:0] x;
            logic [2:0] s, k;
            bit ok, chg, blank;
            hist.push_back({hall, dir_rev, brake_n, stop, pwm});
            if (hist.size() > 2) x = hist.pop_front();
            else                 x = 7'b000_0_1_1_0;
            chg   = (int'(x[3]) != prev_dir) || (int'(x[2]) != prev_brk);
            blank = chg || (dead_left != 0);
            if (chg) dead_left = DEAD;
            else if (dead_left != 0) dead_left = dead_left - 1;
            prev_dir = int'(x[3]);
            prev_brk = int'(x[2]);
            exp_comp = ^x[6:4];
            exp_hi = 3'b000; exp_lo = 3'b000;
            table_lookup(x[3] ? ~x[6:4] : x[6:4], s, k, ok);
            if (x[1]) exp_tag = "R5";
            else if (blank) exp_tag = "R7";
            else if (!x[2]) begin exp_tag = "R4"; exp_hi = 3'b111; end
            else if (!ok) exp_tag = "R3";
            else begin
                exp_tag = x[3] ? "R2" : "R1";
                exp_hi = s;
                if (x[0]) exp_lo = k;
                else exp_tag = "R6";
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            n_chk++;
            if (hi_en !== 3'b000 || lo_en !== 3'b000 || comp !== 1'b0) begin
                n_bad++;
                $display("FAIL R10 reset: hi=%b lo=%b comp=%b expected 000/000/0", hi_en, lo_en, comp);
            end
        end else begin
            n_chk++;
            if (hi_en !== exp_hi || lo_en !== exp_lo) begin
                n_bad++;
                $display("FAIL %s at %0t: hi=%b lo=%b expected hi=%b lo=%b",
                         exp_tag, $time, hi_en, lo_en, exp_hi, exp_lo);
            end
            n_chk++;
            if (comp !== exp_comp) begin
                n_bad++;
                $display("FAIL R8 at %0t: comp=%b expected %b", $time, comp, exp_comp);
            end
            n_chk++;
            if ((hi_en & lo_en) !== 3'b000) begin
                n_bad++;
                $display("FAIL R11 at %0t: hi=%b lo=%b expected disjoint", $time, hi_en, lo_en);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rotate(input int steps, input int hold, input bit chop);
        logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int i = 0; i < steps; i++) begin
            hall = seq[i % 6];
            for (int j = 0; j < hold; j++) begin
                if (chop) pwm = ~pwm;
                @(negedge clk);
            end
        end
        pwm = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(12);
        rotate(12, 4, 1'b0);           // R1
        rotate(12, 3, 1'b1);           // R6
        hall = 3'b000; wait_cyc(5);    // R3
        hall = 3'b111; wait_cyc(5);
        dir_rev = 1'b1; wait_cyc(2);   // R7
        rotate(12, 4, 1'b0);           // R2
        rotate(6, 3, 1'b1);
        brake_n = 1'b0;                // R4
        rotate(6, 3, 1'b0);
        brake_n = 1'b1; wait_cyc(10);
        stop = 1'b1;                   // R5
        rotate(6, 2, 1'b1);
        brake_n = 1'b0; wait_cyc(4);
        stop = 1'b0; wait_cyc(12);
        brake_n = 1'b1; wait_cyc(3);
        dir_rev = 1'b0; wait_cyc(3);   // R7 restart inside window
        dir_rev = 1'b1; wait_cyc(1);
        dir_rev = 1'b0; wait_cyc(12);
        for (int i = 0; i < 3000; i++) begin
            hall = 3'($urandom);
            pwm  = 1'($urandom);
            if ($urandom_range(0, 39) == 0) dir_rev = ~dir_rev;
            if ($urandom_range(0, 49) == 0) brake_n = ~brake_n;
            if ($urandom_range(0, 59) == 0) stop = ~stop;
            @(negedge clk);
        end
        rst_n = 1'b0; wait_cyc(3);     // R10
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule